// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets an on-chip master read and write an external asynchronous static RAM of 65,536 words by 16 bits. The master makes one request at a time over a valid/ready handshake. The request carries a word address, write data, a write flag and two byte-lane enables. The controller converts each accepted request into one timed strobe sequence on the memory pins, and then reports completion with a single-cycle response pulse. For reads, that pulse also carries the captured data.

Reads and writes last the same number of clock cycles. The count is derived at elaboration from the memory speed grade (55, 70, 85 or 100 ns) and the clock period, rounded up. The bidirectional memory data bus is split into an output, an output enable and an input, so the pad ring can build the tri-state buffer. Chip enable is held high whenever no access is running, so the memory stays in its power-down state.

Back-pressure: `req_ready` is high only while the controller is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high, and the master must hold its request fields stable until then. The response has no ready signal: `rsp_valid` is high for one cycle and the master must take it in that cycle.

Top module: `sram_bytelane_ctrl`

## Requirements
- R1: While reset is held, chip enable, output enable, write enable and both lane strobes are high, `sram_dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: Chip enable is high whenever no access is in progress, including in every cycle where `rsp_valid` is high.
- R3: A write with lanes enabled holds chip enable and write enable low, and output enable high, for exactly WAIT cycles. Lane bit 0 drives `sram_lane_n[0]` (data bits 7:0) low and lane bit 1 drives `sram_lane_n[1]` (data bits 15:8) low. Memory lanes that are not enabled keep their old contents.
- R4: A read with lanes enabled holds chip enable and output enable low, and write enable high, for exactly WAIT cycles, with the lane strobes following the enables as in R3.
- R5: Address and lane strobes stay constant for the whole of each access, and the address equals the requested address.
- R6: `sram_dq_oe` is never high while output enable is low. During a write it is high with `sram_dq_out` equal to the write data. It stays high for one cycle after write enable rises, then drops.
- R7: Read data is captured in the last cycle of the access. In `rsp_rdata`, bits 7:0 are zero when lane bit 0 was clear, and bits 15:8 are zero when lane bit 1 was clear.
- R8: A request with both lane enables clear never pulls chip enable low. It gets `rsp_valid` in the first cycle after acceptance, with `rsp_rdata` equal to zero.
- R9: `req_ready` is low from acceptance until the response cycle. `rsp_valid` comes WAIT+1 cycles after acceptance for a read and WAIT+2 cycles after acceptance for a write.
- R10: WAIT equals ceil(ACCESS_NS / CLK_PERIOD_NS). With the defaults of 55 ns and 10 ns, WAIT is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Byte-lane enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| sram_addr | output | 16 | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_lane_n | output | 2 | Byte-lane strobes, active low, bit 0 low byte |
| sram_dq_out | output | 16 | Data driven toward memory |
| sram_dq_oe | output | 1 | Enable for the data output buffer |
| sram_dq_in | input | 16 | Data read from memory |

## Verification
Reads and writes are run with all three nonzero lane patterns. A full-word write followed by single-lane overwrites and a full readback shows whether each strobe really guards only its own byte. A model that drives filler bytes on disabled lanes during reads separates correct zero-masking from data passed straight through. A request with no lanes and a write followed at once by a read expose wrong completion timing, a chip enable that should have stayed high, and a data bus released too early or too late.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_RELEASE} ctrl_state_t;

  function automatic int unsigned wait_cycles(int unsigned access_ns, int unsigned clk_ns);
    return (access_ns + clk_ns - 1) / clk_ns;
  endfunction
endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic last
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (load)      cnt <= CW'(CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CW'(1));

  // R10: the countdown never exceeds the derived wait count
  assert_count_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(CYCLES));

  // R10: a freshly loaded count runs down without reloading or stalling
  assert_count_decrements_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt) != '0 && !$past(load)) |-> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic              capture,
  input  logic [LANES-1:0]  cap_lanes,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned LW = DATA_W / LANES;

  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wdata_q <= '0;
    else if (load) wdata_q <= wdata_in;
  end

  assign dq_out = wdata_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rdata[g*LW +: LW] <= '0;
      else if (capture) rdata[g*LW +: LW] <= cap_lanes[g] ? dq_in[g*LW +: LW] : '0;
    end

    // R7: a lane that was not enabled reads back as zero
    assert_lane_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (capture && !cap_lanes[g]) |=> rdata[g*LW +: LW] == '0);
  end
endmodule

// File: rtl/sram_bytelane_ctrl.sv
module sram_bytelane_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned ACCESS_NS     = 55,
  parameter int unsigned CLK_PERIOD_NS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_lanes,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic                sram_ce_n,
  output logic                sram_oe_n,
  output logic                sram_we_n,
  output logic [DATA_W/8-1:0] sram_lane_n,
  output logic [DATA_W-1:0]   sram_dq_out,
  output logic                sram_dq_oe,
  input  logic [DATA_W-1:0]   sram_dq_in
);
  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned WAIT  = wait_cycles(ACCESS_NS, CLK_PERIOD_NS);

  ctrl_state_t       state;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  lanes_q;
  logic              wr_q;
  logic              rsp_q;
  logic              last;
  logic              accept, null_acc, real_acc, in_access, rd_done, capture;
  logic [LANES-1:0]  cap_lanes;

  assign accept    = req_valid && req_ready;
  assign null_acc  = accept && (req_lanes == '0);
  assign real_acc  = accept && (req_lanes != '0);
  assign in_access = (state == ST_ACCESS);
  assign rd_done   = in_access && last && !wr_q;
  assign capture   = rd_done || null_acc;
  assign cap_lanes = null_acc ? '0 : lanes_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      addr_q  <= '0;
      lanes_q <= '0;
      wr_q    <= 1'b0;
      rsp_q   <= 1'b0;
    end else begin
      rsp_q <= null_acc || rd_done || (state == ST_RELEASE);
      unique case (state)
        ST_IDLE: if (real_acc) begin
          state   <= ST_ACCESS;
          addr_q  <= req_addr;
          lanes_q <= req_lanes;
          wr_q    <= req_write;
        end
        ST_ACCESS:  if (last) state <= wr_q ? ST_RELEASE : ST_IDLE;
        ST_RELEASE: state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

  sram_wait_timer #(.CYCLES(WAIT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (real_acc),
    .last  (last)
  );

  sram_lane_path #(.DATA_W(DATA_W), .LANES(LANES)) u_path (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (real_acc),
    .wdata_in  (req_wdata),
    .capture   (capture),
    .cap_lanes (cap_lanes),
    .dq_in     (sram_dq_in),
    .dq_out    (sram_dq_out),
    .rdata     (rsp_rdata)
  );

  assign req_ready   = (state == ST_IDLE);
  assign rsp_valid   = rsp_q;
  assign sram_addr   = addr_q;
  assign sram_ce_n   = !in_access;
  assign sram_we_n   = !(in_access && wr_q);
  assign sram_oe_n   = !(in_access && !wr_q);
  assign sram_lane_n = in_access ? ~lanes_q : '1;
  assign sram_dq_oe  = wr_q && (in_access || state == ST_RELEASE);

  // R6: the controller never drives data while the memory may be driving
  assert_no_contend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

  // R6: data stays driven through the cycle in which write enable rises
  assert_hold_after_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> sram_dq_oe);

  // R6: the bus is released one cycle after write enable rises
  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |=> !sram_dq_oe);

  // R5: address and lane strobes are constant within an access
  assert_stable_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_lane_n)));

  // R2: chip enable is high whenever a response is presented
  assert_idle_ce_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> sram_ce_n);

  // R8: a request with no lanes completes next cycle without selecting the memory
  assert_null_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_lanes == '0) |=> (rsp_valid && sram_ce_n));

  // R9: an access only begins after a handshake
  assert_start_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_ce_n) |-> $past(req_valid && req_ready));
endmodule

// File: tb/tb_sram_bytelane_ctrl.sv
module tb_sram_bytelane_ctrl;
  localparam int ACC_NS = 55;
  localparam int CLK_NS = 10;
  localparam int W      = (ACC_NS + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_lanes;
  logic        rsp_valid;
  logic [15:0] rsp_rdata, sram_addr, sram_dq_out, sram_dq_in;
  logic        sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [1:0]  sram_lane_n;

  int checks = 0;
  int errors = 0;
  logic [15:0] mem  [0:255];
  logic [15:0] shad [0:255];

  always #5 clk = ~clk;

  sram_bytelane_ctrl #(.ACCESS_NS(ACC_NS), .CLK_PERIOD_NS(CLK_NS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_lanes(req_lanes), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n),
    .sram_we_n(sram_we_n), .sram_lane_n(sram_lane_n), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // memory model: filler bytes on lanes that are not read
  wire rd_on = !sram_ce_n && !sram_oe_n && sram_we_n;
  assign sram_dq_in = { (rd_on && !sram_lane_n[1]) ? mem[sram_addr[7:0]][15:8] : 8'hA5,
                        (rd_on && !sram_lane_n[0]) ? mem[sram_addr[7:0]][7:0]  : 8'h5A };

  always @(posedge clk) begin
    if (!sram_ce_n && !sram_we_n && sram_dq_oe) begin
      if (!sram_lane_n[0]) mem[sram_addr[7:0]][7:0]  <= sram_dq_out[7:0];
      if (!sram_lane_n[1]) mem[sram_addr[7:0]][15:8] <= sram_dq_out[15:8];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] ln, output logic [15:0] rd);
    int n, ce_cnt, rsp_n, exp_rsp;
    bit strobe_bad, addr_bad, busy_bad, drive_bad, rel_bad;
    n = 1; ce_cnt = 0; rsp_n = 0;
    strobe_bad = 0; addr_bad = 0; busy_bad = 0; drive_bad = 0; rel_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_wdata = ~d; req_addr = ~a;
    while (rsp_n == 0 && n < 200) begin
      if (!sram_ce_n) begin
        ce_cnt++;
        if (sram_we_n != !wr || sram_oe_n != wr || sram_lane_n != ~ln) strobe_bad = 1;
        if (sram_addr != a) addr_bad = 1;
        if (wr && (!sram_dq_oe || sram_dq_out != d)) drive_bad = 1;
        if (!wr && sram_dq_oe) drive_bad = 1;
      end
      if (wr && ln != 2'b00 && n == W + 1 && !(sram_dq_oe && sram_we_n && sram_ce_n)) rel_bad = 1;
      if (rsp_valid) rsp_n = n;
      else begin
        if (req_ready) busy_bad = 1;
        @(negedge clk);
        n++;
      end
    end
    exp_rsp = (ln == 2'b00) ? 1 : (wr ? W + 2 : W + 1);
    check(rsp_n == exp_rsp, "R9 response cycle", rsp_n, exp_rsp);
    check(!busy_bad, "R9 ready low while busy", busy_bad, 0);
    check(ce_cnt == ((ln == 2'b00) ? 0 : W), "R10 R8 chip enable low cycles", ce_cnt,
          (ln == 2'b00) ? 0 : W);
    check(!strobe_bad, wr ? "R3 write strobes" : "R4 read strobes", strobe_bad, 0);
    check(!addr_bad, "R5 address held", addr_bad, 0);
    check(!drive_bad, "R6 data drive during access", drive_bad, 0);
    check(!rel_bad, "R6 drive held one cycle after write", rel_bad, 0);
    check(!sram_dq_oe && sram_ce_n, "R6 R2 bus released and deselected at response",
          {sram_dq_oe, sram_ce_n}, 2'b01);
    rd = rsp_rdata;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d, input logic [1:0] ln);
    logic [15:0] rd;
    run_txn(1'b1, a, d, ln, rd);
    if (ln[0]) shad[a[7:0]][7:0]  = d[7:0];
    if (ln[1]) shad[a[7:0]][15:8] = d[15:8];
  endtask

  task automatic do_read(input logic [15:0] a, input logic [1:0] ln, input string tag);
    logic [15:0] rd, exp;
    run_txn(1'b0, a, 16'h0, ln, rd);
    exp = { ln[1] ? shad[a[7:0]][15:8] : 8'h00, ln[0] ? shad[a[7:0]][7:0] : 8'h00 };
    check(rd == exp, tag, rd, exp);
  endtask

  task automatic t_reset;
    check(sram_ce_n && sram_oe_n && sram_we_n && sram_lane_n == 2'b11,
          "R1 strobes high in reset", {sram_ce_n, sram_oe_n, sram_we_n, sram_lane_n}, 5'h1f);
    check(!sram_dq_oe && !rsp_valid && req_ready, "R1 handshake in reset",
          {sram_dq_oe, rsp_valid, req_ready}, 3'b001);
  endtask

  task automatic t_full_word;
    do_write(16'hC312, 16'hBEEF, 2'b11);
    do_read(16'hC312, 2'b11, "R4 R7 full word read");
  endtask

  task automatic t_lane_writes;
    do_write(16'h0040, 16'h1234, 2'b11);
    do_write(16'h0040, 16'hAAFF, 2'b01);
    do_read(16'h0040, 2'b11, "R3 low lane write only");
    do_write(16'h0040, 16'h7700, 2'b10);
    do_read(16'h0040, 2'b11, "R3 high lane write only");
  endtask

  task automatic t_lane_reads;
    do_write(16'h0077, 16'hCAFE, 2'b11);
    do_read(16'h0077, 2'b01, "R7 low lane read masks high");
    do_read(16'h0077, 2'b10, "R7 high lane read masks low");
  endtask

  task automatic t_null;
    logic [15:0] rd;
    run_txn(1'b0, 16'h0077, 16'h0, 2'b00, rd);
    check(rd == 16'h0, "R8 null request data", rd, 0);
    run_txn(1'b1, 16'h0077, 16'h1111, 2'b00, rd);
    do_read(16'h0077, 2'b11, "R8 null write leaves memory");
  endtask

  task automatic t_back_to_back;
    do_write(16'h0099, 16'h5AA5, 2'b11);
    do_read(16'h0099, 2'b11, "R9 read right after write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 16'h0; shad[i] = 16'h0; end
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_lanes = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_full_word;
    t_lane_writes;
    t_lane_reads;
    t_null;
    t_back_to_back;
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule